// File: doc/BRIEF.md
# PHY Error Event Statistics Counters

This block keeps three 16-bit statistics counters for a 10/100 Ethernet physical layer: a link-drop counter, a false-carrier counter and a receive-error packet counter. The physical events are detected elsewhere. This block sees only their indications: a one-cycle drop pulse, a carrier-sense level with a start-delimiter-seen strobe, and the receive framing signals (data valid, receive error and collision).

Each counter follows its own rule when it reaches full scale. The link-drop counter rolls over to zero. The false-carrier counter sticks at all ones. The receive-error counter adds at most one per packet. It does so at the close of the packet, and only when the packet had an error and no collision. The values are read through a combinational port that a 5-bit register index selects.

Top module: `phy_err_stats`

## Requirements
- R1: The link-drop counter adds one on every clock in which `disc_pulse_i` is high, and it rolls from 0xFFFF to 0x0000.
- R2: A rising edge of `crs_i` opens a detection window. The window covers the rise cycle and the next FC_WIN cycles (FC_WIN = 4 by default). If `jk_det_i` is not seen in the window, the false-carrier counter adds exactly one. The add happens in the last cycle of the window, or in the cycle where `crs_i` is sampled low, whichever comes first.
- R3: A carrier assertion is not counted when `jk_det_i` is high in any cycle of its detection window, up to and including the last one.
- R4: The false-carrier counter stops at 0xFFFF and does not wrap.
- R5: The receive-error counter adds one in the cycle where `rx_dv_i` is first sampled low after a packet, when `rx_er_i` was high in at least one cycle of that packet. It never adds while `rx_dv_i` is high, and it never adds more than one per packet.
- R6: A packet is not counted when `col_i` was high in any of its `rx_dv_i` cycles, even when it had receive errors.
- R7: The error and collision flags start fresh with each packet. A packet with no error is not counted, whatever the earlier packets carried.
- R8: Read index 18 returns the link-drop counter, index 19 the false-carrier counter and index 21 the receive-error counter. Every other index returns 0x0000.
- R9: While `rst_ni` is low, all counters are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disc_pulse_i | input | 1 | One link-drop event per high cycle |
| crs_i | input | 1 | Carrier sense level |
| jk_det_i | input | 1 | Start delimiter detected strobe |
| rx_dv_i | input | 1 | Receive data valid (packet framing) |
| rx_er_i | input | 1 | Receive error during the packet |
| col_i | input | 1 | Collision during the packet |
| rd_idx_i | input | 5 | Register index to read |
| rd_data_o | output | 16 | Selected counter value, combinational |

## Verification
The assertions assume that all inputs are synchronous to `clk_i`. They also assume that a packet is the span of consecutive `rx_dv_i` high cycles, and that a carrier assertion is the span of consecutive `crs_i` high cycles. No other framing is implied. The stimulus changes inputs only on falling clock edges and forms packets and carrier bursts as whole spans with gaps of at least one cycle. Within those spans, error, collision, delimiter and drop strobes fall on random cycles. One long run of single-cycle carrier bursts and back-to-back drop pulses drives the false-carrier counter into saturation and makes the link-drop counter wrap.

// File: rtl/phy_stats_pkg.sv
package phy_stats_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned IDX_W   = 5;
  localparam logic [IDX_W-1:0] IDX_DISC = 5'd18;
  localparam logic [IDX_W-1:0] IDX_FC   = 5'd19;
  localparam logic [IDX_W-1:0] IDX_RXE  = 5'd21;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int unsigned W   = 16,
  parameter bit          SAT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic at_max;
  assign at_max = &cnt_o;

  generate
    if (SAT) begin : g_sat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_o <= '0;
        else if (inc_i && !at_max)  cnt_o <= cnt_o + 1'b1;
      end
    end else begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_o <= '0;
        else if (inc_i)  cnt_o <= cnt_o + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fc_detect.sv
module fc_detect #(
  parameter int unsigned FC_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_i,
  input  logic jk_det_i,
  output logic evt_o
);
  localparam int unsigned WIN_W = (FC_WIN < 2) ? 1 : $clog2(FC_WIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(FC_WIN - 1);

  logic             crs_q, armed;
  logic [WIN_W-1:0] win;
  logic             rise, win_end;

  assign rise    = crs_i & ~crs_q;
  assign win_end = (win == WIN_LAST);
  // armed means the carrier is up and no delimiter has been seen yet
  assign evt_o   = armed & ~jk_det_i & (~crs_i | win_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_q <= 1'b0;
      armed <= 1'b0;
      win   <= '0;
    end else begin
      crs_q <= crs_i;
      if (rise) begin
        armed <= ~jk_det_i;
        win   <= '0;
      end else if (armed) begin
        if (jk_det_i || !crs_i || win_end) armed <= 1'b0;
        else                               win   <= win + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_pkt_track.sv
module rx_pkt_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_dv_i,
  input  logic rx_er_i,
  input  logic col_i,
  output logic evt_o
);
  logic dv_q, err_q, col_q;

  assign evt_o = ~rx_dv_i & dv_q & err_q & ~col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      err_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      dv_q <= rx_dv_i;
      if (rx_dv_i && !dv_q) begin
        err_q <= rx_er_i;
        col_q <= col_i;
      end else if (rx_dv_i) begin
        err_q <= err_q | rx_er_i;
        col_q <= col_q | col_i;
      end
    end
  end
endmodule

// File: rtl/phy_err_stats.sv
module phy_err_stats
  import phy_stats_pkg::*;
#(
  parameter int unsigned FC_WIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disc_pulse_i,
  input  logic             crs_i,
  input  logic             jk_det_i,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  input  logic             col_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic             fc_evt, rxe_evt;
  logic [CNT_W-1:0] disc_cnt, fc_cnt, rxe_cnt;

  fc_detect #(.FC_WIN(FC_WIN)) u_fc_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .crs_i(crs_i), .jk_det_i(jk_det_i), .evt_o(fc_evt)
  );

  rx_pkt_track u_rx_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_dv_i(rx_dv_i), .rx_er_i(rx_er_i),
    .col_i(col_i), .evt_o(rxe_evt)
  );

  stat_counter #(.W(CNT_W), .SAT(1'b0)) u_disc_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(disc_pulse_i), .cnt_o(disc_cnt)
  );
  stat_counter #(.W(CNT_W), .SAT(1'b1)) u_fc_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fc_evt), .cnt_o(fc_cnt)
  );
  stat_counter #(.W(CNT_W), .SAT(1'b1)) u_rxe_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(rxe_evt), .cnt_o(rxe_cnt)
  );

  always_comb begin
    unique case (rd_idx_i)
      IDX_DISC: rd_data_o = disc_cnt;
      IDX_FC:   rd_data_o = fc_cnt;
      IDX_RXE:  rd_data_o = rxe_cnt;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/phy_err_stats_chk.sv
module phy_err_stats_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         disc_pulse_i,
  input logic         rx_dv_i,
  input logic [W-1:0] disc_cnt,
  input logic [W-1:0] fc_cnt,
  input logic [W-1:0] rxe_cnt
);
  AST_DISC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disc_pulse_i && (&disc_cnt)) |=> (disc_cnt == '0)); // R1
  AST_DISC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disc_pulse_i |=> $stable(disc_cnt)); // R1
  AST_FC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fc_cnt) |-> (fc_cnt == $past(fc_cnt) + 1'b1)); // R2
  AST_FC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&fc_cnt) |=> (&fc_cnt)); // R4
  AST_RXE_HOLD_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_i |=> $stable(rxe_cnt)); // R5
  AST_RXE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rxe_cnt) |-> (rxe_cnt == $past(rxe_cnt) + 1'b1)); // R5
endmodule

bind phy_err_stats phy_err_stats_chk #(.W(phy_stats_pkg::CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disc_pulse_i(disc_pulse_i), .rx_dv_i(rx_dv_i),
  .disc_cnt(disc_cnt), .fc_cnt(fc_cnt), .rxe_cnt(rxe_cnt)
);

// File: tb/tb_phy_err_stats.sv
module tb_phy_err_stats;
  localparam int FC_WIN = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disc = 1'b0, crs = 1'b0, jk = 1'b0, dv = 1'b0, er = 1'b0, col = 1'b0;
  logic [4:0]  idx = '0;
  logic [15:0] rd;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  phy_err_stats #(.FC_WIN(FC_WIN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .disc_pulse_i(disc), .crs_i(crs), .jk_det_i(jk),
    .rx_dv_i(dv), .rx_er_i(er), .col_i(col), .rd_idx_i(idx), .rd_data_o(rd)
  );

  // behavioural model built from the requirements
  logic [15:0] m_disc = '0, m_fc = '0, m_rxe = '0;
  logic        m_crs_q = 0, m_open = 0, m_dv_q = 0, m_err = 0, m_col = 0;
  int          m_age = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_disc <= '0; m_fc <= '0; m_rxe <= '0;
      m_crs_q <= 0; m_open <= 0; m_age <= 0; m_dv_q <= 0; m_err <= 0; m_col <= 0;
    end else begin
      if (disc) m_disc <= m_disc + 16'd1;                       // R1
      m_crs_q <= crs;
      if (crs && !m_crs_q) begin                                 // R2 window opens
        m_open <= !jk; m_age <= 0;
      end else if (m_open) begin
        if (jk) m_open <= 0;                                     // R3
        else if (!crs || m_age == FC_WIN - 1) begin
          m_open <= 0;
          if (m_fc != 16'hFFFF) m_fc <= m_fc + 16'd1;            // R4
        end else m_age <= m_age + 1;
      end
      m_dv_q <= dv;
      if (dv && !m_dv_q) begin m_err <= er; m_col <= col; end    // R7
      else if (dv) begin m_err <= m_err | er; m_col <= m_col | col; end
      if (!dv && m_dv_q && m_err && !m_col && m_rxe != 16'hFFFF) // R5 R6
        m_rxe <= m_rxe + 16'd1;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [4:0] i);
    case (i)
      5'd18:   return m_disc;
      5'd19:   return m_fc;
      5'd21:   return m_rxe;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input logic [4:0] i, input string req);
    logic [15:0] e;
    idx = i;
    #1;
    e = exp_rd(i);
    total++;
    if (rd !== e) begin
      bad++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", req, i, rd, e);
    end
  endtask

  task automatic chk_all(input string req);
    chk(5'd18, req); chk(5'd19, req); chk(5'd21, req);
  endtask

  task automatic tick; @(negedge clk); endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    tick; tick;
    chk(5'd18, "R9"); chk(5'd19, "R9"); chk(5'd21, "R9");
    rst_ni = 1'b1;
    tick;
    // R8: unmapped indices read zero after counters are nonzero
    disc = 1; tick; disc = 0; tick;
    chk(5'd18, "R1");
    for (int i = 0; i < 32; i++) if (i != 18 && i != 19 && i != 21) chk(5'(i), "R8");

    // R2: carrier with no delimiter, long enough to expire the window
    crs = 1; repeat (FC_WIN + 3) tick; crs = 0; tick; tick;
    chk(5'd19, "R2");
    // R3: delimiter in the last cycle of the window cancels
    crs = 1; tick; repeat (FC_WIN - 1) tick; jk = 1; tick; jk = 0; repeat (3) tick;
    crs = 0; tick; tick;
    chk(5'd19, "R3");
    // R2: delimiter one cycle too late still counts
    crs = 1; tick; repeat (FC_WIN) tick; jk = 1; tick; jk = 0; crs = 0; tick; tick;
    chk(5'd19, "R2");
    // R2: short carrier counted on drop
    crs = 1; tick; crs = 0; tick; tick;
    chk(5'd19, "R2");

    // R5: errored clean packet counted at end
    dv = 1; tick; er = 1; tick; er = 0; tick;
    chk(5'd21, "R5");
    dv = 0; tick;
    chk(5'd21, "R5");
    // R6: errored packet with a collision not counted
    dv = 1; er = 1; tick; er = 0; col = 1; tick; col = 0; tick; dv = 0; tick;
    chk(5'd21, "R6");
    // R7: clean packet after a collision packet not counted
    dv = 1; repeat (3) tick; dv = 0; tick;
    chk(5'd21, "R7");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int len;
      len = 1 + ($urandom % 8);
      dv = ($urandom % 2) != 0;
      crs = ($urandom % 2) != 0;
      for (int c = 0; c < len; c++) begin
        disc = ($urandom % 3) == 0;
        er   = dv && (($urandom % 4) == 0);
        col  = dv && (($urandom % 6) == 0);
        jk   = crs && (($urandom % 5) == 0);
        tick;
      end
      dv = 0; crs = 0; er = 0; col = 0; jk = 0; disc = 0;
      tick;
      chk_all("R5");
    end
    chk_all("R2");

    // R4 and R1: saturate false carrier while the drop counter wraps
    for (int n = 0; n < 65540; n++) begin
      crs = 1; disc = 1; tick;
      crs = 0; tick;
    end
    disc = 0; tick;
    chk(5'd19, "R4");
    chk(5'd18, "R1");
    crs = 1; tick; crs = 0; tick; tick;
    chk(5'd19, "R4");

    // R9: asynchronous reset clears all
    rst_ni = 0; #2;
    chk(5'd18, "R9"); chk(5'd19, "R9"); chk(5'd21, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule